// File: doc/BRIEF.md
# CAN Frame Tail Form and Acknowledge Checker

This block watches the closing part of a CAN frame one sampled bit at a time. A frame sequencer supplies three things. The first is the bus level it sampled, with a strobe that marks the sample point. The second is a code for the field that bit belongs to. The third is a bit that says whether this node sends the frame or receives it. Several fields must always be recessive: the CRC delimiter, the acknowledge delimiter, every end-of-frame bit, and the error and overload delimiters. A dominant sample in any of them is a form error. This also covers a dominant error flag that another node sends over these fields.

The block also handles the acknowledge slot, in two separate ways. A sending node must see a dominant level in that slot, and an acknowledgement error is raised if it does not. A receiving node whose CRC check passed asks to drive dominant for the whole slot. It does this whether or not its filters keep the message. The block reports only the first error of each frame. Any later error stays masked until the next frame start.

Top module: `can_tail_checker`

## Requirements
- R1: After reset, with no strobe and field code 0, all three outputs are low, and the first error of the first frame is reported without a prior frame_start.
- R2: A strobe with bus_level 0 (dominant) and field code 1 (CRC delimiter) raises form_err in that same cycle.
- R3: A strobe with bus_level 0 and field code 3 (acknowledge delimiter) raises form_err in that same cycle.
- R4: A strobe with bus_level 0 and field code 4 (end-of-frame), 5 (error delimiter) or 6 (overload delimiter) raises form_err in that same cycle.
- R5: No form_err is raised for a recessive sample (bus_level 1) in any field. No form_err is raised for a dominant sample in field codes 0, 2 or 7.
- R6: With is_tx 1, a strobe in field code 2 (acknowledge slot) with bus_level 1 raises ack_err in that cycle. A dominant sample there, or any sample while is_tx is 0, gives no ack_err. form_err and ack_err are never high together.
- R7: ack_drive is high while the field code is 2, is_tx is 0 and crc_ok is 1, regardless of the strobe, and is low otherwise. It is also low once an error has been reported in the current frame.
- R8: form_err and ack_err are high only in cycles where sample_strobe is high. Each is a one-cycle pulse per strobe.
- R9: After one error has been reported, later errors (form or acknowledge) are masked until frame_start is sampled high.
- R10: frame_start clears the mask in the same cycle. An error sampled in the same cycle as frame_start is therefore reported, and it then masks the rest of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_strobe | input | 1 | High for one cycle at each bit sample point |
| bus_level | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| field_pos | input | 3 | Field code of the current bit |
| is_tx | input | 1 | 1 when this node sends the frame |
| crc_ok | input | 1 | CRC check result of the received frame |
| frame_start | input | 1 | Marks the start of a new frame, clears the error mask |
| form_err | output | 1 | Form error pulse |
| ack_err | output | 1 | Acknowledgement error pulse (sender only) |
| ack_drive | output | 1 | Request to drive dominant during the acknowledge slot |

## Verification
The bench targets the field codes next to the checked ones: code 2 for form checking, and codes 0 and 7. A decoder that is off by one would flag those codes or miss a delimiter. It applies dominant samples while the strobe is low. A design that does not gate on the strobe would then pulse between sample points. It also places an error in the same cycle as frame_start. A design that clears the mask one cycle late would drop that error, and one that never masks would report a second error in the same frame. Finally, it switches is_tx and crc_ok during the acknowledge slot, which exposes an ack error raised on a receiver or an ack drive requested without a good CRC.

// File: rtl/can_tail_pkg.sv
package can_tail_pkg;

  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    FP_OTHER     = 3'd0,
    FP_CRC_DELIM = 3'd1,
    FP_ACK_SLOT  = 3'd2,
    FP_ACK_DELIM = 3'd3,
    FP_EOF       = 3'd4,
    FP_ERR_DELIM = 3'd5,
    FP_OVL_DELIM = 3'd6,
    FP_SPARE     = 3'd7
  } field_e;

  localparam logic LVL_DOMINANT  = 1'b0;
  localparam logic LVL_RECESSIVE = 1'b1;

  // Fields whose fixed form is recessive.
  function automatic logic needs_recessive(field_e f);
    case (f)
      FP_CRC_DELIM, FP_ACK_DELIM, FP_EOF, FP_ERR_DELIM, FP_OVL_DELIM: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_ack_slot(field_e f);
    return f == FP_ACK_SLOT;
  endfunction

endpackage

// File: rtl/can_tail_field_dec.sv
module can_tail_field_dec
  import can_tail_pkg::*;
(
  input  logic [FIELD_W-1:0] field_pos,
  output logic               fixed_rec,
  output logic               ack_slot
);
  field_e fld;

  always_comb begin
    fld       = field_e'(field_pos);
    fixed_rec = needs_recessive(fld);
    ack_slot  = is_ack_slot(fld);
  end

  always_comb begin
    AST_DEC_EXCLUSIVE: assert (!(fixed_rec && ack_slot)); // R5
  end
endmodule

// File: rtl/can_tail_form_chk.sv
module can_tail_form_chk
  import can_tail_pkg::*;
(
  input  logic sample_strobe,
  input  logic bus_level,
  input  logic fixed_rec,
  input  logic masked,
  output logic form_hit
);
  logic violation;

  always_comb begin
    violation = sample_strobe && fixed_rec && (bus_level == LVL_DOMINANT);
    form_hit  = violation && !masked;
  end
endmodule

// File: rtl/can_tail_ack_ctl.sv
module can_tail_ack_ctl
  import can_tail_pkg::*;
(
  input  logic sample_strobe,
  input  logic bus_level,
  input  logic ack_slot,
  input  logic is_tx,
  input  logic crc_ok,
  input  logic masked,
  output logic ack_hit,
  output logic drive_req
);
  logic missing_ack;

  always_comb begin
    missing_ack = sample_strobe && ack_slot && is_tx && (bus_level == LVL_RECESSIVE);
    ack_hit     = missing_ack && !masked;
    drive_req   = ack_slot && !is_tx && crc_ok && !masked;
  end
endmodule

// File: rtl/can_tail_err_latch.sv
module can_tail_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic err_any,
  input  logic sample_strobe,
  output logic masked
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_q <= 1'b0;
    else if (frame_start) seen_q <= err_any;
    else if (err_any)     seen_q <= 1'b1;
  end

  always_comb masked = seen_q && !frame_start;

  AST_ONE_ERR_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> (!err_any || frame_start)); // R9
  AST_ERR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> sample_strobe); // R8
  AST_START_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !masked); // R10
endmodule

// File: rtl/can_tail_checker.sv
module can_tail_checker
  import can_tail_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_strobe,
  input  logic               bus_level,
  input  logic [FIELD_W-1:0] field_pos,
  input  logic               is_tx,
  input  logic               crc_ok,
  input  logic               frame_start,
  output logic               form_err,
  output logic               ack_err,
  output logic               ack_drive
);
  logic fixed_rec, ack_slot, masked, form_hit, ack_hit, drive_req, err_any;

  can_tail_field_dec u_dec (
    .field_pos (field_pos),
    .fixed_rec (fixed_rec),
    .ack_slot  (ack_slot)
  );

  can_tail_form_chk u_form (
    .sample_strobe (sample_strobe),
    .bus_level     (bus_level),
    .fixed_rec     (fixed_rec),
    .masked        (masked),
    .form_hit      (form_hit)
  );

  can_tail_ack_ctl u_ack (
    .sample_strobe (sample_strobe),
    .bus_level     (bus_level),
    .ack_slot      (ack_slot),
    .is_tx         (is_tx),
    .crc_ok        (crc_ok),
    .masked        (masked),
    .ack_hit       (ack_hit),
    .drive_req     (drive_req)
  );

  always_comb err_any = form_hit || ack_hit;

  can_tail_err_latch u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .err_any       (err_any),
    .sample_strobe (sample_strobe),
    .masked        (masked)
  );

  assign form_err  = form_hit;
  assign ack_err   = ack_hit;
  assign ack_drive = drive_req;

  AST_NO_DUAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(form_err && ack_err)); // R6
  AST_FORM_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    form_err |-> (bus_level == LVL_DOMINANT)); // R2
  AST_DRIVE_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> (!is_tx && crc_ok && field_pos == FP_ACK_SLOT)); // R7
  AST_ACK_ERR_TX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (is_tx && bus_level == LVL_RECESSIVE)); // R6
endmodule

// File: tb/tb_can_tail_checker.sv
module tb_can_tail_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, bus = 1'b1, tx = 1'b0, crc = 1'b0, fs = 1'b0;
  logic [2:0] fld = 3'd0;
  logic form_err, ack_err, ack_drive;

  int checks = 0;
  int errors = 0;
  bit seen = 0;  // model: an error already reported in this frame

  always #10 clk = ~clk;  // 50 MHz

  can_tail_checker dut (
    .clk(clk), .rst_n(rst_n), .sample_strobe(strobe), .bus_level(bus),
    .field_pos(fld), .is_tx(tx), .crc_ok(crc), .frame_start(fs),
    .form_err(form_err), .ack_err(ack_err), .ack_drive(ack_drive)
  );

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic cmp(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, name, act, exp);
    end
  endtask

  // One bit-time: drive at negedge, compare mid-cycle, advance model.
  task automatic step(string tag, bit s, bit b, int f, bit t, bit c, bit st);
    bit mask, chk, ef, ea, ed;
    @(negedge clk);
    strobe = s; bus = b; fld = 3'(f); tx = t; crc = c; fs = st;
    #5;
    mask = seen && !st;
    chk  = (f == 1) || (f == 3) || (f == 4) || (f == 5) || (f == 6);
    ef   = s && !b && chk && !mask;
    ea   = s && b && (f == 2) && t && !mask;
    ed   = (f == 2) && !t && c && !mask;
    cmp(tag, "form_err", form_err, ef);
    cmp(tag, "ack_err", ack_err, ea);
    cmp(tag, "ack_drive", ack_drive, ed);
    if (st) seen = ef || ea;
    else if (ef || ea) seen = 1;
  endtask

  initial begin
    #3;
    #2;
    cmp("R1", "form_err", form_err, 1'b0);
    cmp("R1", "ack_err", ack_err, 1'b0);
    cmp("R1", "ack_drive", ack_drive, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: first error after reset reported without frame_start
    step("R1", 1, 0, 1, 0, 0, 0);
    // R2 + R9: CRC delimiter dominant, then masked
    step("R2", 1, 0, 1, 0, 0, 1);
    step("R9", 1, 0, 3, 0, 0, 0);
    step("R9", 1, 1, 2, 1, 0, 0);
    step("R7", 0, 1, 2, 0, 1, 0);   // ack_drive suppressed after error
    // R3
    step("R3", 1, 0, 3, 1, 0, 1);
    // R4: each of EOF, error delimiter, overload delimiter
    for (int f = 4; f <= 6; f++) step("R4", 1, 0, f, 0, 0, 1);
    // R5: recessive everywhere, dominant in 0, 2 and 7
    step("R5", 0, 1, 0, 0, 0, 1);
    for (int f = 0; f < 8; f++) step("R5", 1, 1, f, 0, 0, 0);
    step("R5", 1, 0, 0, 1, 0, 0);
    step("R5", 1, 0, 7, 1, 0, 0);
    step("R5", 1, 0, 2, 0, 1, 0);
    // R6: sender ack slot
    step("R6", 1, 0, 2, 1, 0, 1);
    step("R6", 1, 1, 2, 0, 1, 0);
    step("R6", 1, 1, 2, 1, 0, 0);
    // R7: drive requests
    step("R7", 0, 1, 2, 0, 1, 1);
    step("R7", 1, 0, 2, 0, 1, 0);
    step("R7", 0, 1, 2, 0, 0, 0);
    step("R7", 0, 1, 2, 1, 1, 0);
    step("R7", 0, 1, 3, 0, 1, 0);
    // R8: dominant without strobe
    step("R8", 0, 0, 1, 0, 0, 1);
    step("R8", 0, 0, 4, 0, 0, 0);
    step("R8", 0, 1, 2, 1, 0, 0);
    step("R8", 1, 0, 4, 0, 0, 0);
    step("R8", 0, 0, 5, 0, 0, 0);
    // R10: error in same cycle as frame_start while latched
    step("R10", 1, 0, 6, 0, 0, 0);
    step("R10", 1, 0, 4, 0, 0, 1);
    step("R10", 1, 0, 5, 0, 0, 0);
    step("R10", 1, 1, 2, 1, 0, 1);
    // random phase against the model
    for (int i = 0; i < 400; i++)
      step("RAND", 1'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
           1'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule